// File: doc/BRIEF.md
# Modem Control and Status Block with Loopback

This block sits beside the serial engines of an asynchronous serial port. It keeps a small control register that drives four active-low handshake outputs: terminal ready, request to send, and two general-purpose outputs. The second general-purpose output also gates the port's interrupt onto its output pin. The block watches four active-low handshake inputs: clear to send, data set ready, ring and carrier detect. It presents their asserted state together with one change flag per line. A change flag is set when its line changes and stays set until the status register is read.

A loopback bit in the control register lets the port test itself. While it is set, the external handshake outputs and the serial output are forced to their idle levels. The status inputs are taken from the low four control bits instead of the pins. The transmit serial stream is fed back as the receive serial stream. The host bus decoder, the serial shifters and the interrupt arbiter connect to this block through plain strobes and data ports.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After synchronous reset the control readback is 0x00, every active-low output (`dtr_n`, `rts_n`, `out1_n`, `out2_n`) is 1, `pin_txd` and `core_rxd` are 1, `irq_out` and `msr_irq` are 0 and the status readback is 0x00.
- R2: A write stores data bits 4..0 in the control register: bit 0 terminal ready, bit 1 request to send, bit 2 general output 1, bit 3 general output 2, bit 4 loopback. The register takes the value at the write edge, and `ctl_rd_data` returns those five bits with bits 7..5 reading 0.
- R3: Outside loopback, each active-low output equals the inverse of its control bit one clock after the control register changes, and `pin_txd` equals `core_txd` delayed by one clock.
- R4: Status bits 7..4 give the asserted state of carrier detect (7), ring (6), data set ready (5) and clear to send (4). A line counts as asserted when its pin is low. A pin change appears three clock edges after it is applied: two synchronizer stages and the status register.
- R5: Status bits 3..0 are change flags for carrier detect (3), ring (2), data set ready (1) and clear to send (0). A flag is set in the same edge that its state bit changes, and it holds until a status read.
- R6: A status read (`sts_rd_en` high for one cycle) returns the value held before that edge and clears every change flag at that edge. A state change landing at the same edge sets its flag again.
- R7: In loopback, the status state bits follow control bits 0..3 as clear to send, data set ready, ring and carrier detect, one edge after the control register. The external handshake pins have no effect.
- R8: In loopback, all four active-low outputs and `pin_txd` are driven 1, and `core_rxd` equals `core_txd` delayed by one clock. Outside loopback, `core_rxd` follows `pin_rxd` three edges later.
- R9: `msr_irq` is 1 exactly while at least one change flag is set.
- R10: `irq_out` equals `irq_in` ANDed with control bit 3, registered one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control write data |
| ctl_rd_data | output | 8 | Control register readback |
| sts_rd_en | input | 1 | Status read strobe, clears change flags |
| sts_rd_data | output | 8 | Status register value |
| cts_n | input | 1 | Clear to send pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Terminal ready pin, active low |
| rts_n | output | 1 | Request to send pin, active low |
| out1_n | output | 1 | General output 1 pin, active low |
| out2_n | output | 1 | General output 2 pin, active low |
| core_txd | input | 1 | Serial stream from the transmit shifter |
| pin_txd | output | 1 | Serial output pin |
| pin_rxd | input | 1 | Serial input pin |
| core_rxd | output | 1 | Serial stream to the receive shifter |
| irq_in | input | 1 | Port interrupt from the arbiter |
| irq_out | output | 1 | Gated interrupt pin |
| msr_irq | output | 1 | Modem status change request |

## Verification
Several properties are checked on every cycle. Change flags never drop without a read. Every state change leaves its flag set. Loopback forces the pins idle and returns the transmit stream. The output gate of the interrupt is also checked each cycle. Only the bench scenarios can show the exact latencies from pin to status, the bit positions of each line, the clearing at a read that coincides with a change, and that external pins are ignored in loopback. Those scenarios compare whole status words read through the normal strobe.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int REG_W   = 8;
  localparam int NLINES  = 4;
  localparam int CTL_USED = 5;

  // line index order shared by status state and change flags
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  typedef logic [NLINES-1:0] mdm_lines_t;

  // packed so that bit positions match the readback word
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mdm_ctl_t;
endpackage

// File: rtl/uart_mdm_sync.sv
module uart_mdm_sync #(
  parameter int                WIDTH   = 1,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/uart_mdm_ctl.sv
module uart_mdm_ctl
  import uart_mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output mdm_ctl_t         ctl,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             out1_n,
  output logic             out2_n,
  input  logic             core_txd,
  output logic             pin_txd,
  input  logic             rxd_sync,
  output logic             core_rxd,
  input  logic             irq_in,
  output logic             irq_out
);
  mdm_ctl_t ctl_q;
  logic     unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:CTL_USED];

  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= '0;
    else if (wr_en) ctl_q <= mdm_ctl_t'(wr_data[CTL_USED-1:0]);
  end

  assign ctl     = ctl_q;
  assign rd_data = {{(REG_W-CTL_USED){1'b0}}, ctl_q};

  // registered pin drivers; loopback forces the idle level
  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_n    <= 1'b1;
      rts_n    <= 1'b1;
      out1_n   <= 1'b1;
      out2_n   <= 1'b1;
      pin_txd  <= 1'b1;
      core_rxd <= 1'b1;
      irq_out  <= 1'b0;
    end else begin
      dtr_n    <= ctl_q.loop | ~ctl_q.dtr;
      rts_n    <= ctl_q.loop | ~ctl_q.rts;
      out1_n   <= ctl_q.loop | ~ctl_q.out1;
      out2_n   <= ctl_q.loop | ~ctl_q.out2;
      pin_txd  <= ctl_q.loop | core_txd;
      core_rxd <= ctl_q.loop ? core_txd : rxd_sync;
      irq_out  <= irq_in & ctl_q.out2;
    end
  end

  a_r8_loop_pins_idle: assert property (@(posedge clk) disable iff (rst)
    ctl_q.loop |=> (dtr_n && rts_n && out1_n && out2_n && pin_txd));
  a_r8_loop_return: assert property (@(posedge clk) disable iff (rst)
    ctl_q.loop |=> (core_rxd == $past(core_txd)));
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.out2 |=> !irq_out);
  a_r3_txd_follows: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.loop |=> (pin_txd == $past(core_txd)));
endmodule

// File: rtl/uart_mdm_sts.sv
module uart_mdm_sts
  import uart_mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             loop,
  input  mdm_lines_t       ctl_lines,
  input  mdm_lines_t       ext_lines,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  mdm_lines_t src;
  mdm_lines_t cur_q;
  mdm_lines_t delta_q;
  mdm_lines_t chg;
  mdm_lines_t delta_nx;

  assign src = loop ? ctl_lines : ext_lines;
  assign chg = src ^ cur_q;

  always_comb begin
    delta_nx = rd_en ? '0 : delta_q;
    delta_nx = delta_nx | chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      delta_q <= '0;
    end else begin
      cur_q   <= src;
      delta_q <= delta_nx;
    end
  end

  assign rd_data = {cur_q, delta_q};
  assign irq     = |delta_q;

  a_r5_flag_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  a_r5_change_flagged: assert property (@(posedge clk) disable iff (rst)
    ((cur_q ^ $past(cur_q)) & ~delta_q) == '0);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && src == cur_q) |=> (delta_q == '0));
  a_r7_loop_source: assert property (@(posedge clk) disable iff (rst)
    loop |=> (cur_q == $past(ctl_lines)));
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
  import uart_mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  output logic [REG_W-1:0] ctl_rd_data,
  input  logic             sts_rd_en,
  output logic [REG_W-1:0] sts_rd_data,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             ri_n,
  input  logic             dcd_n,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             out1_n,
  output logic             out2_n,
  input  logic             core_txd,
  output logic             pin_txd,
  input  logic             pin_rxd,
  output logic             core_rxd,
  input  logic             irq_in,
  output logic             irq_out,
  output logic             msr_irq
);
  localparam int SYNC_W = NLINES + 1;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn_in;
  mdm_lines_t        ext_lines;
  mdm_lines_t        ctl_lines;
  mdm_ctl_t          ctl;

  assign raw_in = {pin_rxd, dcd_n, ri_n, dsr_n, cts_n};

  uart_mdm_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({SYNC_W{1'b1}})
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_in),
    .q  (syn_in)
  );

  assign ext_lines = ~syn_in[NLINES-1:0];
  assign ctl_lines = {ctl.out2, ctl.out1, ctl.rts, ctl.dtr};

  uart_mdm_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .rd_data (ctl_rd_data),
    .ctl     (ctl),
    .dtr_n   (dtr_n),
    .rts_n   (rts_n),
    .out1_n  (out1_n),
    .out2_n  (out2_n),
    .core_txd(core_txd),
    .pin_txd (pin_txd),
    .rxd_sync(syn_in[NLINES]),
    .core_rxd(core_rxd),
    .irq_in  (irq_in),
    .irq_out (irq_out)
  );

  uart_mdm_sts u_sts (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (sts_rd_en),
    .loop     (ctl.loop),
    .ctl_lines(ctl_lines),
    .ext_lines(ext_lines),
    .rd_data  (sts_rd_data),
    .irq      (msr_irq)
  );

  a_r9_irq_tracks_flags: assert property (@(posedge clk) disable iff (rst)
    msr_irq |-> (sts_rd_data[NLINES-1:0] != '0));
endmodule

// File: tb/uart_modem_ctrl_tb_top.sv
module uart_modem_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr_en = 1'b0;
  logic [7:0] ctl_wr_data = '0;
  logic [7:0] ctl_rd_data;
  logic sts_rd_en = 1'b0;
  logic [7:0] sts_rd_data;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic dtr_n, rts_n, out1_n, out2_n;
  logic core_txd = 1'b1;
  logic pin_txd;
  logic pin_rxd = 1'b1;
  logic core_rxd;
  logic irq_in = 1'b0;
  logic irq_out, msr_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  uart_modem_ctrl dut_i (
    .clk(clk), .rst(rst),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .sts_rd_en(sts_rd_en), .sts_rd_data(sts_rd_data),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .core_txd(core_txd), .pin_txd(pin_txd), .pin_rxd(pin_rxd), .core_rxd(core_rxd),
    .irq_in(irq_in), .irq_out(irq_out), .msr_irq(msr_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_wr_en = 1'b1;
    ctl_wr_data = v;
    tick(1);
    ctl_wr_en = 1'b0;
  endtask

  // driver: pushes the expected status word, then strobes a read
  task automatic read_sts(input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    sts_rd_en = 1'b1;
    tick(1);
    sts_rd_en = 1'b0;
  endtask

  // monitor: mid-cycle compare of each strobed read against the queue
  always @(negedge clk) begin
    if (!rst && sts_rd_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected read", sts_rd_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(sts_rd_data == e, t, sts_rd_data, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(ctl_rd_data == 8'h00, "R1 ctl", ctl_rd_data, 0);
    check({dtr_n, rts_n, out1_n, out2_n} == 4'hF, "R1 pins", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
    check(pin_txd && core_rxd, "R1 serial", {pin_txd, core_rxd}, 3);
    check(!irq_out && !msr_irq, "R1 irq", {irq_out, msr_irq}, 0);
    check(sts_rd_data == 8'h00, "R1 sts", sts_rd_data, 0);

    // R2 write, upper bits dropped
    write_ctl(8'hEB);
    check(ctl_rd_data == 8'h0B, "R2 readback", ctl_rd_data, 8'h0B);
    check(dtr_n == 1'b1, "R3 before latency", dtr_n, 1);
    tick(1);
    check({dtr_n, rts_n, out1_n, out2_n} == 4'b0010, "R3 pins", {dtr_n, rts_n, out1_n, out2_n}, 4'b0010);
    core_txd = 1'b0;
    tick(1);
    check(pin_txd == 1'b0, "R3 txd low", pin_txd, 0);
    core_txd = 1'b1;
    tick(1);
    check(pin_txd == 1'b1, "R3 txd high", pin_txd, 1);

    // R10 interrupt gate
    irq_in = 1'b1;
    tick(1);
    check(irq_out == 1'b1, "R10 pass", irq_out, 1);
    write_ctl(8'h03);
    tick(1);
    check(irq_out == 1'b0, "R10 gated", irq_out, 0);
    irq_in = 1'b0;

    // R8 normal receive path latency
    pin_rxd = 1'b0;
    tick(2);
    check(core_rxd == 1'b1, "R8 rxd early", core_rxd, 1);
    tick(1);
    check(core_rxd == 1'b0, "R8 rxd", core_rxd, 0);

    // R4 R5 single line
    cts_n = 1'b0;
    tick(2);
    check(sts_rd_data == 8'h00, "R4 early", sts_rd_data, 0);
    tick(1);
    check(msr_irq == 1'b1, "R9 set", msr_irq, 1);
    read_sts(8'h11, "R4 cts");
    check(msr_irq == 1'b0, "R9 clear", msr_irq, 0);
    read_sts(8'h10, "R6 cleared");

    // R4 R5 two lines, flags held
    dsr_n = 1'b0;
    dcd_n = 1'b0;
    tick(13);
    read_sts(8'hBA, "R5 dsr dcd held");
    cts_n = 1'b1;
    tick(3);
    read_sts(8'hA1, "R5 cts release");
    read_sts(8'hA0, "R6 clean");

    // R6 change lands on the read edge
    ri_n = 1'b0;
    tick(2);
    read_sts(8'hA0, "R6 coincident read");
    read_sts(8'hE4, "R6 flag kept");
    read_sts(8'hE0, "R6 clean again");

    // R7 R8 loopback
    write_ctl(8'h15);
    tick(1);
    check({dtr_n, rts_n, out1_n, out2_n} == 4'hF, "R8 loop pins", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
    core_txd = 1'b0;
    tick(1);
    check(pin_txd == 1'b1, "R8 loop txd idle", pin_txd, 1);
    check(core_rxd == 1'b0, "R8 loop return low", core_rxd, 0);
    core_txd = 1'b1;
    tick(1);
    check(core_rxd == 1'b1, "R8 loop return high", core_rxd, 1);
    read_sts(8'h5B, "R7 loop source");
    cts_n = 1'b0;
    tick(4);
    read_sts(8'h50, "R7 pins ignored");
    write_ctl(8'h1A);
    tick(1);
    read_sts(8'hAF, "R7 all lines");

    // leave loopback
    write_ctl(8'h00);
    tick(1);
    read_sts(8'hF5, "R4 back to pins");
    core_txd = 1'b0;
    tick(1);
    check(pin_txd == 1'b0, "R3 txd after loop", pin_txd, 0);
    core_txd = 1'b1;
    tick(2);
    check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule